// File: doc/BRIEF.md
# Serial Byte Transceiver with Fractional Baud Divider

This block moves bytes between a register port and a pair of asynchronous serial pins. A byte written to the data address is queued, then shifted out on the transmit pin. A frame holds one low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The receive pin is sampled with a 16x oversampling tick. Each character that arrives goes into a receive queue, and software reads it back through the same data address.

The tick comes from a divider with an integer part and a 6-bit fractional part. The fractional part is added into an accumulator on every tick. When the accumulator carries, the next tick period is one clock longer, so the average bit time is 16 x (integer + fraction/64) clocks. Parity can be off, even, odd or stick (a constant bit). A control bit cuts both queues down to a single byte each. The receiver drops start bits that do not last until their mid-point. It records parity, framing and overrun errors in sticky status bits, and software clears each of these by writing 1 to it.

The transmitter has five states: IDLE, START, DATA, PARITY and STOP. Transitions: IDLE->START on a tick while a byte is queued. START->DATA after 16 ticks. DATA->PARITY, or DATA->STOP when parity is off, after the last data bit. PARITY->STOP after 16 ticks. STOP->IDLE after the last stop bit. The receiver has the same five states. Transitions: IDLE->START on a tick that sees the line low. START->IDLE (false start) or START->DATA on the 8th tick. DATA->PARITY or DATA->STOP after the last bit. PARITY->STOP after 16 ticks. STOP->IDLE on the 16th tick, when the character is delivered.

Top module: `uart_core`

## Requirements
- R1: The data field length is set by control bits [1:0] (0=5, 1=6, 2=7, 3=8 bits). Received characters are read with the unused upper bits at zero.
- R2: A transmitted frame starts with one low start bit, followed by the data bits least significant bit first.
- R3: Control bit [2] selects two stop bits (1) or one stop bit (0), and the transmitter drives every stop bit high. A receive stop bit sampled low sets the framing error flag, status bit 3.
- R4: Control bit [3] enables parity, bit [4] selects odd (1) or even (0), and bit [5] selects stick mode, in which the parity bit is the constant value of bit [4]. The transmitter generates the parity bit and the receiver checks it. A mismatch sets status bit 2.
- R5: The oversampling tick period is the integer divisor (address 2, 0 treated as 1) in clocks, plus one clock whenever the 6-bit accumulator fed by the fractional divisor (address 3, bits [5:0]) carries. A start bit lasts 16 ticks, which is 16 x (I + F/64) clocks to within one clock.
- R6: A low level on the receive line that is no longer low at the 8th tick after it is seen is a false start. No character is delivered and no error is flagged.
- R7: Control bit [6] cuts each queue to one byte. The transmit-full flag (status bit 1) is then set by one byte waiting. With the bit clear, each queue holds 8 bytes.
- R8: A character that arrives while the receive queue is full is discarded, and the overrun flag (status bit 4) is set. Characters already stored are kept.
- R9: After reset, the transmit line is high and the status reads 0x01 (receive queue empty, all other bits zero). The line stays high between frames.
- R10: Reading address 0 returns the oldest received character and removes it. Writing 1 to status bits 2 to 4 (address 4) clears them. Status bit 0 shows the receive queue empty and bit 5 shows the transmitter active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_addr | input | 3 | Register address: 0 data, 1 control, 2 integer divisor, 3 fractional divisor, 4 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
A wrong tick counter or accumulator in the baud divider shows up on the transmit line within the first start bit, because its low width moves away from 16 x (I + F/64) clocks. A bit counter or shift register in the wrong state changes the data or parity bits of the very next frame. In loopback the same fault also shows up in the character read back one bit time after the stop bit. A fault in the receive queue or the error flags is visible at the status register as soon as the affected character has been delivered, at the mid-point of its stop bit.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int DIV_W  = 8;
    localparam int FRAC_W = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } ser_state_t;

    typedef struct packed {
        logic       fifo_off;
        logic       par_stick;
        logic       par_odd;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len;
    } frame_cfg_t;

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t c);
        logic [7:0] m;
        m = d & len_mask(c.len);
        if (c.par_stick) return c.par_odd;
        return (^m) ^ c.par_odd;
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              tick_o
);
    logic [DIV_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic [DIV_W-1:0]  base;

    always_comb begin
        acc_sum = {1'b0, acc} + {1'b0, div_frac_i};
        base    = (div_int_i == '0) ? DIV_W'(1) : div_int_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            acc    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == '0) begin
            tick_o <= 1'b1;
            acc    <= acc_sum[FRAC_W-1:0];
            cnt    <= base - DIV_W'(1) + DIV_W'(acc_sum[FRAC_W]);
        end else begin
            tick_o <= 1'b0;
            cnt    <= cnt - DIV_W'(1);
        end
    end

    // R5: with a divisor of two or more, ticks never come on adjacent clocks
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && $past(div_int_i) >= 2 |=> !tick_o);

endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    always_comb begin
        empty_o = (count == '0);
        full_o  = single_i ? (count != '0) : (count >= (AW+1)'(DEPTH));
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        dout_o  = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R7: a push into a full store without a pop leaves the occupancy unchanged
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i |=> count == $past(count));

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  frame_cfg_t cfg_i,
    input  logic       avail_i,
    input  logic [7:0] din_i,
    output logic       pop_o,
    output logic       txd_o,
    output logic       busy_o
);
    ser_state_t state, nstate;
    logic [3:0] tcnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       par_q;
    logic       stop_idx;
    logic       bit_end;
    logic [2:0] last_bit;

    always_comb begin
        bit_end  = tick_i && (tcnt == 4'd15);
        last_bit = {1'b0, cfg_i.len} + 3'd4;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (tick_i && avail_i) nstate = S_START;
            S_START:  if (bit_end) nstate = S_DATA;
            S_DATA:   if (bit_end && bitn == last_bit)
                          nstate = cfg_i.par_en ? S_PARITY : S_STOP;
            S_PARITY: if (bit_end) nstate = S_STOP;
            S_STOP:   if (bit_end && (stop_idx == cfg_i.two_stop)) nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bitn     <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            stop_idx <= 1'b0;
        end else if (state == S_IDLE) begin
            if (pop_o) begin
                shreg    <= din_i;
                par_q    <= parity_of(din_i, cfg_i);
                tcnt     <= '0;
                bitn     <= '0;
                stop_idx <= 1'b0;
            end
        end else if (tick_i) begin
            tcnt <= tcnt + 4'd1;
            if (bit_end && state == S_DATA) begin
                shreg <= shreg >> 1;
                bitn  <= bitn + 3'd1;
            end
            if (bit_end && state == S_STOP) stop_idx <= 1'b1;
        end
    end

    always_comb begin
        pop_o  = (state == S_IDLE) && tick_i && avail_i;
        busy_o = (state != S_IDLE);
        unique case (state)
            S_START:  txd_o = 1'b0;
            S_DATA:   txd_o = shreg[0];
            S_PARITY: txd_o = par_q;
            default:  txd_o = 1'b1;
        endcase
    end

    // R5: a frame only begins on a clock that carried a baud tick
    a_r5_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(tick_i));

    // R2: the line is driven low for the clock right after a frame begins
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  frame_cfg_t cfg_i,
    input  logic       rxd_i,
    output logic       push_o,
    output logic [7:0] data_o,
    output logic       perr_o,
    output logic       ferr_o
);
    ser_state_t state, nstate;
    logic       s1, s2;
    logic [3:0] tcnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       perr_q;
    logic       bit_end;
    logic [2:0] last_bit;
    logic [7:0] aligned;

    always_comb begin
        bit_end  = tick_i && (tcnt == 4'd15);
        last_bit = {1'b0, cfg_i.len} + 3'd4;
        aligned  = shreg >> (2'd3 - cfg_i.len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd_i;
            s2 <= s1;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (tick_i && !s2) nstate = S_START;
            S_START:  if (tick_i && tcnt == 4'd7) nstate = s2 ? S_IDLE : S_DATA;
            S_DATA:   if (bit_end && bitn == last_bit)
                          nstate = cfg_i.par_en ? S_PARITY : S_STOP;
            S_PARITY: if (bit_end) nstate = S_STOP;
            S_STOP:   if (bit_end) nstate = S_IDLE;
            default:  nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt   <= '0;
            bitn   <= '0;
            shreg  <= '0;
            perr_q <= 1'b0;
        end else if (tick_i) begin
            unique case (state)
                S_IDLE: begin
                    tcnt   <= '0;
                    bitn   <= '0;
                    perr_q <= 1'b0;
                end
                S_START: tcnt <= (tcnt == 4'd7) ? 4'd0 : tcnt + 4'd1;
                S_DATA: begin
                    tcnt <= tcnt + 4'd1;
                    if (bit_end) begin
                        shreg <= {s2, shreg[7:1]};
                        bitn  <= bitn + 3'd1;
                    end
                end
                S_PARITY: begin
                    tcnt <= tcnt + 4'd1;
                    if (bit_end) perr_q <= (s2 != parity_of(aligned, cfg_i));
                end
                default: tcnt <= tcnt + 4'd1;
            endcase
        end
    end

    always_comb begin
        push_o = (state == S_STOP) && bit_end;
        data_o = aligned & len_mask(cfg_i.len);
        perr_o = perr_q;
        ferr_o = !s2;
    end

    // R6: a start bit found high at its mid-point sends the receiver back to idle
    a_r6_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_START && tick_i && tcnt == 4'd7 && s2 |=> state == S_IDLE && !push_o);

endmodule

// File: rtl/uart_core.sv
module uart_core
    import uart_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       txd_o,
    input  logic       rxd_i
);
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_DIVI = 3'd2;
    localparam logic [2:0] A_DIVF = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    logic [6:0]        ctrl_q;
    logic [DIV_W-1:0]  divi_q;
    logic [FRAC_W-1:0] divf_q;
    logic              perr_q, ferr_q, ovr_q;
    frame_cfg_t        cfg;
    logic              tick;

    logic       txf_push, txf_pop, txf_empty, txf_full;
    logic [7:0] txf_dout;
    logic       tx_busy;

    logic       rx_push, rx_perr, rx_ferr;
    logic [7:0] rx_data;
    logic       rxf_pop, rxf_empty, rxf_full;
    logic [7:0] rxf_dout;
    logic       clr_wr;

    always_comb begin
        cfg      = frame_cfg_t'(ctrl_q);
        txf_push = reg_wr && reg_addr == A_DATA;
        rxf_pop  = reg_rd && reg_addr == A_DATA;
        clr_wr   = reg_wr && reg_addr == A_STAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 7'h03;
            divi_q <= DIV_W'(1);
            divf_q <= '0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[6:0];
            if (reg_wr && reg_addr == A_DIVI) divi_q <= reg_wdata[DIV_W-1:0];
            if (reg_wr && reg_addr == A_DIVF) divf_q <= reg_wdata[FRAC_W-1:0];
            perr_q <= (perr_q && !(clr_wr && reg_wdata[2])) || (rx_push && rx_perr);
            ferr_q <= (ferr_q && !(clr_wr && reg_wdata[3])) || (rx_push && rx_ferr);
            ovr_q  <= (ovr_q  && !(clr_wr && reg_wdata[4])) || (rx_push && rxf_full);
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = rxf_dout;
            A_CTRL:  reg_rdata = {1'b0, ctrl_q};
            A_DIVI:  reg_rdata = 8'(divi_q);
            A_DIVF:  reg_rdata = 8'(divf_q);
            A_STAT:  reg_rdata = {2'b00, tx_busy || !txf_empty, ovr_q, ferr_q, perr_q,
                                  txf_full, rxf_empty};
            default: reg_rdata = 8'h00;
        endcase
    end

    uart_baud i_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_int_i  (divi_q),
        .div_frac_i (divf_q),
        .tick_o     (tick)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .single_i (cfg.fifo_off),
        .push_i   (txf_push),
        .din_i    (reg_wdata),
        .pop_i    (txf_pop),
        .dout_o   (txf_dout),
        .empty_o  (txf_empty),
        .full_o   (txf_full)
    );

    uart_tx i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .cfg_i   (cfg),
        .avail_i (!txf_empty),
        .din_i   (txf_dout),
        .pop_o   (txf_pop),
        .txd_o   (txd_o),
        .busy_o  (tx_busy)
    );

    uart_rx i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .cfg_i  (cfg),
        .rxd_i  (rxd_i),
        .push_o (rx_push),
        .data_o (rx_data),
        .perr_o (rx_perr),
        .ferr_o (rx_ferr)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .single_i (cfg.fifo_off),
        .push_i   (rx_push),
        .din_i    (rx_data),
        .pop_i    (rxf_pop),
        .dout_o   (rxf_dout),
        .empty_o  (rxf_empty),
        .full_o   (rxf_full)
    );

    // R8: a character delivered into a full receive store raises the overrun flag
    a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rxf_full |=> ovr_q);

    // R3: a delivered character whose stop bit was low raises the framing flag
    a_r3_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_ferr |=> ferr_q);

    // R8: the overrun push leaves the stored character at the head unchanged
    a_r8_keep_head: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rxf_full && !rxf_pop |=> $stable(rxf_dout));

endmodule

// File: tb/test_uart_core.sv
module test_uart_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       txd;
    logic       drv_rx = 1'b1;
    logic       loop = 1'b0;
    logic       rxd;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    assign rxd = loop ? txd : drv_rx;

    uart_core i_uart_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .txd_o     (txd),
        .rxd_i     (rxd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(input logic [7:0] d, input int nb);
        return d & 8'((1 << nb) - 1);
    endfunction

    function automatic bit exp_par(input logic [7:0] d, input int nb, input bit odd, input bit stick);
        int ones = 0;
        if (stick) return odd;
        for (int i = 0; i < nb; i++) ones += d[i];
        return (ones % 2 == 1) ^ odd;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit pop, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = pop;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int k = 0; k < 400; k++) begin
            rd(3'd4, 1'b0, st);
            if (!st[5]) break;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic capture(input int nb, input bit pe, input bit ts, input int d, input int f,
                           output logic [7:0] dv, output bit pv, output bit sv, output bit sb);
        int t0;
        int nbits;
        bit v;
        t0 = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!txd) begin t0 = cyc; break; end
        end
        dv = 8'h00; pv = 1'b0; sv = 1'b1; sb = 1'b0;
        if (t0 < 0) return;
        nbits = 1 + nb + int'(pe) + 1 + int'(ts);
        for (int i = 0; i < nbits; i++) begin
            while (cyc < t0 + ((2*i+1) * (64*d + f)) / 8) @(negedge clk);
            v = txd;
            if (i == 0) sb = !v;
            else if (i <= nb) dv[i-1] = v;
            else if (pe && i == nb + 1) pv = v;
            else sv = sv & v;
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input int nb, input bit pe, input bit pb, input bit sv);
        localparam int B = 16;
        @(negedge clk);
        drv_rx = 1'b0; repeat (B) @(negedge clk);
        for (int i = 0; i < nb; i++) begin drv_rx = d[i]; repeat (B) @(negedge clk); end
        if (pe) begin drv_rx = pb; repeat (B) @(negedge clk); end
        drv_rx = sv; repeat (B) @(negedge clk);
        drv_rx = 1'b1; repeat (2*B) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, rv, dv;
        bit pv, sv, sb;
        int w;
        int unsigned seed;
        seed = $urandom(32'd2024);

        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R9 line idle after reset", int'(txd), 1);
        rd(3'd4, 1'b0, st);
        chk(st == 8'h01, "R9 reset status", st, 8'h01);

        // R5: start bit width with I=3, F=32 is 56 clocks; with I=2, F=0 it is 32
        wr(3'd1, 8'h03); wr(3'd2, 8'd3); wr(3'd3, 8'd32); wr(3'd0, 8'hFF);
        for (int k = 0; k < 2000 && txd; k++) @(negedge clk);
        w = 0;
        while (!txd && w < 5000) begin @(negedge clk); w++; end
        chk(w >= 55 && w <= 57, "R5 start width I=3 F=32", w, 56);
        wait_idle();
        wr(3'd2, 8'd2); wr(3'd3, 8'd0); wr(3'd0, 8'hFF);
        for (int k = 0; k < 2000 && txd; k++) @(negedge clk);
        w = 0;
        while (!txd && w < 5000) begin @(negedge clk); w++; end
        chk(w >= 31 && w <= 33, "R5 start width I=2 F=0", w, 32);
        wait_idle();
        chk(txd === 1'b1, "R9 line high between frames", int'(txd), 1);

        // random frames in loopback: R1 R2 R3 R4 R5
        for (int it = 0; it < 30; it++) begin
            int nb, d, f;
            bit ts, pe, od, sk;
            logic [7:0] dat;
            nb = 5 + int'($urandom % 4);
            ts = 1'($urandom); pe = 1'($urandom); od = 1'($urandom); sk = 1'($urandom);
            d = 1 + int'($urandom % 3); f = int'($urandom % 64);
            dat = 8'($urandom);
            if (it == 0) begin nb = 5; pe = 1; sk = 1; od = 1; end
            if (it == 1) begin nb = 8; pe = 1; sk = 1; od = 0; ts = 1; end
            loop = 1'b1;
            wr(3'd1, {1'b0, sk, od, pe, ts, 2'(nb - 5)});
            wr(3'd2, 8'(d)); wr(3'd3, 8'(f));
            wr(3'd0, dat);
            capture(nb, pe, ts, d, f, dv, pv, sv, sb);
            chk(sb, "R2 start bit low", int'(sb), 1);
            chk(dv == msk(dat, nb), "R2 data bits lsb first", dv, msk(dat, nb));
            if (pe) chk(pv == exp_par(dat, nb, od, sk), "R4 parity bit generated",
                        int'(pv), int'(exp_par(dat, nb, od, sk)));
            chk(sv, "R3 stop bits high", int'(sv), 1);
            repeat (64 * d) @(negedge clk);
            rd(3'd4, 1'b0, st);
            chk(st[4:0] == 5'b00000, "R4 loopback status clean", st[4:0], 0);
            rd(3'd0, 1'b1, rv);
            chk(rv == msk(dat, nb), "R1 received length and zero upper bits", rv, msk(dat, nb));
            wait_idle();
        end
        loop = 1'b0;

        // directed receive cases at 16 clocks per bit
        wr(3'd2, 8'd1); wr(3'd3, 8'd0); wr(3'd1, 8'h03);
        @(negedge clk); drv_rx = 1'b0;
        repeat (5) @(negedge clk); drv_rx = 1'b1;
        repeat (300) @(negedge clk);
        rd(3'd4, 1'b0, st);
        chk(st[4:0] == 5'b00001, "R6 false start delivers nothing", st, 8'h01);
        send_rx(8'hA5, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd0, 1'b1, rv);
        chk(rv == 8'hA5, "R6 receiver recovers after false start", rv, 8'hA5);

        send_rx(8'h3C, 8, 1'b0, 1'b0, 1'b0);
        rd(3'd4, 1'b0, st);
        chk(st[3] == 1'b1, "R3 framing error flagged", st[3], 1);
        rd(3'd0, 1'b1, rv);
        wr(3'd4, 8'h1C);
        rd(3'd4, 1'b0, st);
        chk(st == 8'h01, "R10 status cleared by write of ones", st, 8'h01);

        wr(3'd1, 8'h3B); // 8 bits, parity on, odd, stick
        send_rx(8'h55, 8, 1'b1, 1'b1, 1'b1);
        rd(3'd4, 1'b0, st);
        chk(st[2] == 1'b0, "R4 stick parity accepted", st[2], 0);
        rd(3'd0, 1'b1, rv);
        send_rx(8'h55, 8, 1'b1, 1'b0, 1'b1);
        rd(3'd4, 1'b0, st);
        chk(st[2] == 1'b1, "R4 stick parity mismatch flagged", st[2], 1);
        rd(3'd0, 1'b1, rv);
        wr(3'd4, 8'h1C);

        wr(3'd1, 8'h43); // single-byte mode
        send_rx(8'h11, 8, 1'b0, 1'b0, 1'b1);
        send_rx(8'h22, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd4, 1'b0, st);
        chk(st[4] == 1'b1, "R8 overrun flagged", st[4], 1);
        rd(3'd0, 1'b1, rv);
        chk(rv == 8'h11, "R8 first byte kept", rv, 8'h11);
        rd(3'd4, 1'b0, st);
        chk(st[0] == 1'b1, "R10 read pops the only byte", st[0], 1);
        wr(3'd4, 8'h1C);

        wr(3'd1, 8'h03);
        send_rx(8'h31, 8, 1'b0, 1'b0, 1'b1);
        send_rx(8'h32, 8, 1'b0, 1'b0, 1'b1);
        send_rx(8'h33, 8, 1'b0, 1'b0, 1'b1);
        rd(3'd4, 1'b0, st);
        chk(st[4] == 1'b0, "R7 queue holds three bytes", st[4], 0);
        for (int k = 0; k < 3; k++) begin
            rd(3'd0, 1'b1, rv);
            chk(rv == 8'(8'h31 + k), "R7 queue order", rv, 8'h31 + k);
        end

        wr(3'd1, 8'h43);
        wr(3'd0, 8'h81);
        repeat (40) @(negedge clk);
        wr(3'd0, 8'h82);
        rd(3'd4, 1'b0, st);
        chk(st[1] == 1'b1, "R7 one waiting byte fills transmit side", st[1], 1);
        wait_idle();
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h81);
        repeat (40) @(negedge clk);
        wr(3'd0, 8'h82);
        rd(3'd4, 1'b0, st);
        chk(st[1] == 1'b0, "R7 deep queue not full", st[1], 0);
        chk(st[5] == 1'b1, "R10 transmitter active flag", st[5], 1);
        wait_idle();
        chk(txd === 1'b1, "R9 line high after drain", int'(txd), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule